// File: doc/BRIEF.md
# Shared Mailbox Bank with Level Interrupts

This block holds a small bank of one-word mailboxes. Each mailbox carries a message from one producer to one consumer. The top bit of the stored word is the FULL flag and the lower 31 bits are the payload. A producer marks a message present by writing a word with the top bit set. The consumer takes the message and then writes zero, which empties the mailbox.

Every mailbox drives two level conditions, EMPTY and FULL. The block gathers them into one status word. Each interrupt output has its own enable word with the same bit layout. An output is high while any enabled condition is present. When the block is built with local enables, each mailbox window also holds a FULL enable and an EMPTY enable, and a condition only reaches the outputs when both its local enable and its shared enable bit are set. A read-only capability word reports the counts the block was built with.

Reads and writes use a simple single-cycle register bus. A write takes effect at the clock edge where the request is sampled. Read data is registered and appears in the cycle after the read request.

Top module: `mbx_array`

## Requirements
- R1: Writing a mailbox data word (window offset 0x0) stores all 32 bits, and a later read returns them. Bit 31 is the FULL flag. When the same mailbox is written twice in a row, the later write is the one kept.
- R2: Writing zero to a mailbox data word clears both the payload and the FULL flag. The mailbox then reads 0 and shows as empty.
- R3: The status word at 0x304 holds the EMPTY bit of mailbox i at bit i and its FULL bit at bit 8+i. Bits of mailboxes that are not built read 0, and bus writes to the status word are ignored.
- R4: Interrupt output n has an enable word at 0x100 + 4*n with the status layout. Only bits of built mailboxes are stored. The output is high exactly when status AND enable AND local gate is non-zero.
- R5: The interrupt is level-sensitive. It stays high while the enabled condition lasts and falls once the mailbox state changes, for example when the consumer clears a full mailbox.
- R6: The read-only capability word at 0x380 holds the mailbox count in bits 3:0, two other resource counts in bits 7:4 and 11:8, the doorbell count in bits 15:12 and the interrupt-output count in bits 19:16. Writes to it are ignored.
- R7: When local enables are built, window offset 0x4 is the FULL enable and offset 0x8 is the EMPTY enable. Each is held in bit 0 and reads back as 0 or 1. A condition whose local enable is 0 cannot raise any output.
- R8: Mailbox i sits in its own window at 0x1000 + i*0x100. An access inside one window leaves every other mailbox unchanged.
- R9: Reads of unmapped offsets return 0. This covers unused window offsets and the windows of mailboxes that are not built. Read data is valid in the cycle after the read request.
- R10: After reset, every mailbox word, enable word and local enable is 0, every output is low, and the status word shows all built mailboxes as empty. The capability word reflects the parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, sampled at the clock edge |
| bus_we | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | N_IRQ | Level interrupt outputs, one per enable word |

## Verification
The assertions check on every cycle that:
- a zero write empties the mailbox;
- an idle mailbox word holds its value;
- an output with an all-zero enable word stays low;
- a raised output stays up while its conditions and gates are unchanged;
- capability reads and unmapped reads return their fixed values.

Other behaviours can only be shown by the bench scenarios:
- the bit placement of the status word;
- the filtering of enable bits for mailboxes that are not built;
- the AND of local and shared enables;
- the isolation between mailbox windows;
- which of two writes to the same mailbox is kept.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned COND_W   = 16;
    localparam int unsigned FULL_BIT = 31;
    localparam int unsigned MAX_MBOX = 8;

    localparam logic [ADDR_W-1:0] IE_BASE     = 16'h0100;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'h0304;
    localparam logic [ADDR_W-1:0] CAPS_ADDR   = 16'h0380;
    localparam logic [ADDR_W-1:0] MBOX_BASE   = 16'h1000;
    localparam int unsigned       WIN_LG      = 8;

    localparam logic [7:0] OFS_WORD     = 8'h00;
    localparam logic [7:0] OFS_FULL_EN  = 8'h04;
    localparam logic [7:0] OFS_EMPTY_EN = 8'h08;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MBOX,
        SEL_IE,
        SEL_STATUS,
        SEL_CAPS
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [3:0] idx;
        logic [7:0] ofs;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] addr,
                                    input int n_mbox, input int n_irq);
        dec_t d;
        logic [ADDR_W-1:0] rel;
        d.sel = SEL_NONE;
        d.idx = '0;
        d.ofs = '0;
        rel   = addr - MBOX_BASE;
        if (addr == STATUS_ADDR) begin
            d.sel = SEL_STATUS;
        end else if (addr == CAPS_ADDR) begin
            d.sel = SEL_CAPS;
        end else if (addr >= IE_BASE && addr[1:0] == 2'b00 &&
                     int'(addr - IE_BASE) < 4 * n_irq) begin
            d.sel = SEL_IE;
            d.idx = 4'((addr - IE_BASE) >> 2);
        end else if (addr >= MBOX_BASE && int'(rel >> WIN_LG) < n_mbox) begin
            d.sel = SEL_MBOX;
            d.idx = 4'(rel >> WIN_LG);
            d.ofs = rel[7:0];
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] caps_word(input int n_mbox, input int n_a,
                                                    input int n_b, input int n_db,
                                                    input int n_irq);
        return {12'h000, 4'(n_irq), 4'(n_db), 4'(n_b), 4'(n_a), 4'(n_mbox)};
    endfunction

    function automatic logic [COND_W-1:0] impl_mask(input int n_mbox);
        logic [7:0] m;
        m = 8'((9'd1 << n_mbox) - 9'd1);
        return {m, m};
    endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter bit HAS_LOCAL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_o,
    output logic              full_o,
    output logic              full_en_o,
    output logic              empty_en_o
);

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)                            word_q <= '0;
        else if (wr_en && ofs == OFS_WORD)  word_q <= wdata;
    end

    assign word_o = word_q;
    assign full_o = word_q[FULL_BIT];

    generate
        if (HAS_LOCAL_EN) begin : g_local
            logic full_en_q, empty_en_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    full_en_q  <= 1'b0;
                    empty_en_q <= 1'b0;
                end else if (wr_en) begin
                    if (ofs == OFS_FULL_EN)  full_en_q  <= wdata[0];
                    if (ofs == OFS_EMPTY_EN) empty_en_q <= wdata[0];
                end
            end
            assign full_en_o  = full_en_q;
            assign empty_en_o = empty_en_q;
        end else begin : g_nolocal
            assign full_en_o  = 1'b1;
            assign empty_en_o = 1'b1;
        end
    endgenerate

    // R2
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ofs == OFS_WORD && wdata == '0) |=> (word_o == '0 && !full_o));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word_o));

endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
    import mbx_pkg::*;
#(
    parameter int N_MBOX = 4,
    parameter int N_IRQ  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ie_wr,
    input  logic [3:0]              ie_idx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [COND_W-1:0]       cond,
    input  logic [COND_W-1:0]       gate,
    output logic [N_IRQ*COND_W-1:0] ie_flat,
    output logic [N_IRQ-1:0]        irq_o
);

    localparam logic [COND_W-1:0] IMPL = impl_mask(N_MBOX);

    logic [COND_W-1:0] live;
    assign live = cond & gate;

    generate
        for (genvar n = 0; n < N_IRQ; n++) begin : g_out
            logic [COND_W-1:0] ie_q;
            always_ff @(posedge clk) begin
                if (rst)                                  ie_q <= '0;
                else if (ie_wr && ie_idx == 4'(n))        ie_q <= wdata[COND_W-1:0] & IMPL;
            end
            assign ie_flat[n*COND_W +: COND_W] = ie_q;
            assign irq_o[n] = |(live & ie_q);

            // R4
            masked_off_chk: assert property (@(posedge clk) disable iff (rst)
                (ie_q == '0) |-> !irq_o[n]);

            // R5
            level_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (irq_o[n] && !ie_wr) |=>
                    (irq_o[n] || cond != $past(cond) || gate != $past(gate)));
        end
    endgenerate

endmodule

// File: rtl/mbx_array.sv
module mbx_array
    import mbx_pkg::*;
#(
    parameter int N_MBOX       = 4,
    parameter int N_IRQ        = 2,
    parameter bit HAS_LOCAL_EN = 1'b1,
    parameter int N_RES_A      = 2,
    parameter int N_RES_B      = 1,
    parameter int N_DOORBELL   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [15:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_IRQ-1:0]  irq_o
);

    localparam logic [DATA_W-1:0] CAPS = caps_word(N_MBOX, N_RES_A, N_RES_B, N_DOORBELL, N_IRQ);

    dec_t dec;
    assign dec = decode(bus_addr, N_MBOX, N_IRQ);

    logic                    wr, rd;
    logic [DATA_W-1:0]       words [N_MBOX];
    logic [N_MBOX-1:0]       full, full_en, empty_en;
    logic [COND_W-1:0]       status, gate;
    logic [N_IRQ*COND_W-1:0] ie_flat;
    logic [DATA_W-1:0]       rd_mux, rdata_q;

    assign wr = bus_req && bus_we;
    assign rd = bus_req && !bus_we;

    generate
        for (genvar i = 0; i < N_MBOX; i++) begin : g_mbox
            mbx_slot #(.HAS_LOCAL_EN(HAS_LOCAL_EN)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .wr_en      (wr && dec.sel == SEL_MBOX && dec.idx == 4'(i)),
                .ofs        (dec.ofs),
                .wdata      (bus_wdata),
                .word_o     (words[i]),
                .full_o     (full[i]),
                .full_en_o  (full_en[i]),
                .empty_en_o (empty_en[i])
            );
        end
    endgenerate

    always_comb begin
        status = '0;
        gate   = '0;
        for (int i = 0; i < N_MBOX; i++) begin
            status[i]   = !full[i];
            status[8+i] = full[i];
            gate[i]     = empty_en[i];
            gate[8+i]   = full_en[i];
        end
    end

    mbx_irq_gen #(.N_MBOX(N_MBOX), .N_IRQ(N_IRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .ie_wr   (wr && dec.sel == SEL_IE),
        .ie_idx  (dec.idx),
        .wdata   (bus_wdata),
        .cond    (status),
        .gate    (gate),
        .ie_flat (ie_flat),
        .irq_o   (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (dec.sel)
            SEL_STATUS: rd_mux = {16'h0000, status};
            SEL_CAPS:   rd_mux = CAPS;
            SEL_IE: begin
                for (int n = 0; n < N_IRQ; n++)
                    if (dec.idx == 4'(n)) rd_mux = {16'h0000, ie_flat[n*COND_W +: COND_W]};
            end
            SEL_MBOX: begin
                for (int i = 0; i < N_MBOX; i++) begin
                    if (dec.idx == 4'(i)) begin
                        if (dec.ofs == OFS_WORD) rd_mux = words[i];
                        else if (HAS_LOCAL_EN && dec.ofs == OFS_FULL_EN)  rd_mux = {31'h0, full_en[i]};
                        else if (HAS_LOCAL_EN && dec.ofs == OFS_EMPTY_EN) rd_mux = {31'h0, empty_en[i]};
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R6
    caps_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && dec.sel == SEL_CAPS) |=> (bus_rdata == CAPS));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && dec.sel == SEL_NONE) |=> (bus_rdata == '0));

    // R3
    status_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && dec.sel == SEL_STATUS) |=> (bus_rdata[31:16] == '0 &&
            $countones(bus_rdata[15:0]) == N_MBOX));

endmodule

// File: tb/test_mbx_array.sv
module test_mbx_array;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbx_array i_mbx_array (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    localparam logic [31:0] CAPS_EXP = 32'h0002_3124;

    function automatic logic [15:0] mb(input int i, input int ofs);
        return 16'(32'h1000 + i * 32'h100 + ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R10 irq after reset", 32'(irq_o), 32'h0);
        rd(16'h0304, d); check("R10 status after reset", d, 32'h0000_000F);
        rd(16'h0100, d); check("R10 enable0 after reset", d, 32'h0);
        rd(mb(0, 0), d); check("R10 mailbox0 after reset", d, 32'h0);
        rd(mb(2, 4), d); check("R10 local enable after reset", d, 32'h0);
        rd(16'h0380, d); check("R6 caps word", d, CAPS_EXP);
    endtask

    task automatic t_read_only;
        logic [31:0] d;
        wr(16'h0380, 32'hFFFF_FFFF);
        rd(16'h0380, d); check("R6 caps write ignored", d, CAPS_EXP);
        wr(16'h0304, 32'hFFFF_FFFF);
        rd(16'h0304, d); check("R3 status write ignored", d, 32'h0000_000F);
    endtask

    task automatic t_mailbox;
        logic [31:0] d;
        wr(mb(2, 0), 32'h8000_1234);
        rd(mb(2, 0), d); check("R1 mailbox2 readback", d, 32'h8000_1234);
        rd(16'h0304, d); check("R3 status with mailbox2 full", d, 32'h0000_040B);
        rd(mb(1, 0), d); check("R8 mailbox1 untouched", d, 32'h0);
        rd(mb(3, 0), d); check("R8 mailbox3 untouched", d, 32'h0);
        wr(mb(0, 0), 32'h8000_0001);
        wr(mb(0, 0), 32'h8000_0002);
        rd(mb(0, 0), d); check("R1 later write kept", d, 32'h8000_0002);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(mb(2, 0), 32'h0);
        wr(mb(0, 0), 32'h0);
        rd(mb(2, 0), d); check("R2 mailbox2 cleared", d, 32'h0);
        rd(16'h0304, d); check("R2 status all empty", d, 32'h0000_000F);
    endtask

    task automatic t_irq_full;
        wr(mb(1, 4), 32'h1);
        wr(16'h0100, 32'h0000_0200);
        check("R4 no irq before full", 32'(irq_o), 32'h0);
        wr(mb(1, 0), 32'h8000_00AA);
        check("R4 irq0 on mailbox1 full", 32'(irq_o), 32'h1);
        repeat (3) @(negedge clk);
        check("R5 irq0 held while full", 32'(irq_o), 32'h1);
        wr(mb(1, 0), 32'h0);
        check("R5 irq0 drops after clear", 32'(irq_o), 32'h0);
    endtask

    task automatic t_local_gate;
        logic [31:0] d;
        wr(mb(1, 4), 32'h0);
        wr(mb(1, 0), 32'h8000_0055);
        check("R7 local FULL enable off blocks irq", 32'(irq_o), 32'h0);
        wr(mb(1, 0), 32'h0);
        wr(mb(2, 8), 32'hFFFF_FFFF);
        rd(mb(2, 8), d); check("R7 local enable reads bit0", d, 32'h1);
        wr(mb(2, 8), 32'h0);
        rd(mb(2, 8), d); check("R7 local enable cleared", d, 32'h0);
    endtask

    task automatic t_empty;
        logic [31:0] d;
        wr(16'h0104, 32'h0000_0008);
        check("R7 empty not raised without local enable", 32'(irq_o), 32'h0);
        wr(mb(3, 8), 32'h1);
        check("R4 irq1 on mailbox3 empty", 32'(irq_o), 32'h2);
        wr(mb(3, 0), 32'h8000_0005);
        check("R5 irq1 drops when mailbox3 fills", 32'(irq_o), 32'h0);
        wr(16'h0100, 32'hFFFF_FFFF);
        rd(16'h0100, d); check("R4 enable keeps built bits only", d, 32'h0000_0F0F);
        check("R7 gated conditions keep irq low", 32'(irq_o), 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(mb(0, 0), d);
        rd(16'h0200, d); check("R9 unmapped common offset", d, 32'h0);
        rd(16'h1400, d); check("R9 window of missing mailbox", d, 32'h0);
        rd(mb(3, 12), d); check("R9 unused window offset", d, 32'h0);
        rd(16'h0108, d); check("R9 enable of missing output", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_only();
        t_mailbox();
        t_clear();
        t_irq_full();
        t_local_gate();
        t_empty();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule